// File: doc/BRIEF.md
# Fixed Segment Address Mapper

This block translates a 32-bit virtual address into a physical address for a processor that has no translation lookaside buffer. A fixed map splits the virtual space into four segments, selected by the top three address bits. Each segment has its own relocation rule and cache attribute. A mode input marks user or kernel accesses. User code may reach only the lower half of the address space. Any user attempt above that raises an address-error flag, and the access is dropped.

The lower 2 GB segment is shared by both modes and is relocated upward by a fixed offset. Two kernel windows, starting at 0x80000000 and 0xA0000000, both alias physical memory from address zero. The second window is the uncached one, used for boot code and I/O. The top quarter maps to itself. Reserved sub-ranges inside the segments get no special handling and translate like the rest of their segment. An optional output register, on by default, adds one cycle of latency and cuts the combinational path.

Top module: `seg_addr_mapper`

## Requirements
- R1: A request with vaddr bit 31 clear, in either mode, gives paddr = vaddr + 0x40000000 (modulo 2^32) with cacheable = 1.
- R2: A kernel request (user_mode = 0) with vaddr[31:29] = 3'b100 gives paddr = vaddr with bits 31:29 cleared and cacheable = 1.
- R3: A kernel request with vaddr[31:29] = 3'b101 gives paddr = vaddr with bits 31:29 cleared and cacheable = 0.
- R4: A kernel request with vaddr[31:30] = 2'b11 gives paddr = vaddr and cacheable = 1.
- R5: A user request (user_mode = 1) with vaddr bit 31 set gives addr_err = 1, out_valid = 0, paddr = 0 and cacheable = 0.
- R6: The 1 MB reserved ranges at the top of the user segment (0x7FF00000–0x7FFFFFFF) and at the top of the address space (0xFFF00000–0xFFFFFFFF) translate by their segment's rule and raise no error.
- R7: With REG_OUT = 1, the results for a request appear on the outputs one clock after the edge that samples it. A cycle with req_valid = 0 gives out_valid = 0, addr_err = 0, paddr = 0 and cacheable = 0 on the next cycle.
- R8: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is present |
| vaddr | input | 32 | Virtual address |
| user_mode | input | 1 | 1 = user access, 0 = kernel access |
| out_valid | output | 1 | A translated access is issued |
| paddr | output | 32 | Physical address (0 when not valid) |
| cacheable | output | 1 | The access may be cached |
| addr_err | output | 1 | A user access fell outside the user segment |

## Verification
On every request, the assertions check four things: a user access above the user segment is refused, the uncached window yields an uncached access with its top bits cleared, the user segment is relocated by the fixed offset, and the top segment passes through unchanged. They also check that an idle cycle leaves the outputs quiet. Only the bench's directed scenarios show the exact boundary addresses on either side of each segment edge, and that the reserved megabyte ranges translate without error. They also show kernel accesses to the user segment and the reset values.

// File: rtl/seg_addr_mapper.sv
module seg_addr_mapper #(
  parameter int AW = 32,
  parameter logic [AW-1:0] USER_OFFSET = 32'h4000_0000,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] vaddr,
  input  logic          user_mode,
  output logic          out_valid,
  output logic [AW-1:0] paddr,
  output logic          cacheable,
  output logic          addr_err
);

  localparam int SEG_W = 3;
  localparam int LOW_W = AW - SEG_W;

  logic [SEG_W-1:0] seg;
  logic             fault;
  logic [AW-1:0]    map_addr;
  logic             map_cach;
  logic             n_valid, n_err, n_cach;
  logic [AW-1:0]    n_paddr;

  assign seg   = vaddr[AW-1 -: SEG_W];
  assign fault = user_mode & seg[SEG_W-1];

  always_comb begin
    map_addr = vaddr;
    map_cach = 1'b1;
    unique casez (seg)
      3'b0??: map_addr = vaddr + USER_OFFSET;
      3'b100: map_addr = {{SEG_W{1'b0}}, vaddr[LOW_W-1:0]};
      3'b101: begin
        map_addr = {{SEG_W{1'b0}}, vaddr[LOW_W-1:0]};
        map_cach = 1'b0;
      end
      default: map_addr = vaddr;
    endcase
  end

  assign n_valid = req_valid & ~fault;
  assign n_err   = req_valid & fault;
  assign n_paddr = n_valid ? map_addr : '0;
  assign n_cach  = n_valid & map_cach;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          paddr     <= '0;
          cacheable <= 1'b0;
          addr_err  <= 1'b0;
        end else begin
          out_valid <= n_valid;
          paddr     <= n_paddr;
          cacheable <= n_cach;
          addr_err  <= n_err;
        end
      end

      assert_user_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && user_mode && vaddr[AW-1] |=> addr_err && !out_valid && !cacheable);

      assert_uncached_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !user_mode && vaddr[AW-1 -: SEG_W] == 3'b101
        |=> out_valid && !cacheable && paddr[AW-1 -: SEG_W] == 3'b000);

      assert_user_reloc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !vaddr[AW-1]
        |=> out_valid && cacheable && paddr == $past(vaddr) + USER_OFFSET);

      assert_top_identity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !user_mode && vaddr[AW-1 -: 2] == 2'b11
        |=> out_valid && cacheable && paddr == $past(vaddr));

      assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid && !addr_err);
    end else begin : g_comb
      assign out_valid = n_valid;
      assign paddr     = n_paddr;
      assign cacheable = n_cach;
      assign addr_err  = n_err;
    end
  endgenerate

endmodule

// File: tb/seg_addr_mapper_test.sv
`timescale 1ns/1ps
module seg_addr_mapper_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic        user_mode = 1'b0;
  logic        out_valid, cacheable, addr_err;
  logic [31:0] paddr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_addr_mapper #(.AW(32), .USER_OFFSET(32'h4000_0000), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
    .user_mode(user_mode), .out_valid(out_valid), .paddr(paddr),
    .cacheable(cacheable), .addr_err(addr_err)
  );

  task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got v=%b e=%b c=%b pa=%h, expected v=%b e=%b c=%b pa=%h",
               req, act[34], act[33], act[32], act[31:0], exp[34], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic xlate(input string req, input logic v, input logic um, input logic [31:0] va,
                       input logic ev, input logic ee, input logic ec, input logic [31:0] epa);
    @(negedge clk);
    req_valid = v; user_mode = um; vaddr = va;
    @(posedge clk);
    #2;
    check(req, {out_valid, addr_err, cacheable, paddr}, {ev, ee, ec, epa});
  endtask

  task automatic test_reset();
    @(posedge clk); #2;
    check("R8", {out_valid, addr_err, cacheable, paddr}, 35'd0);
    @(negedge clk); req_valid = 1'b1; vaddr = 32'h8000_0010;
    @(posedge clk); #2;
    check("R8", {out_valid, addr_err, cacheable, paddr}, 35'd0);
    @(negedge clk); rst_n = 1'b1; req_valid = 1'b0;
  endtask

  task automatic test_user_segment();
    xlate("R1", 1, 1, 32'h0000_0000, 1, 0, 1, 32'h4000_0000);
    xlate("R1", 1, 1, 32'h1234_5678, 1, 0, 1, 32'h5234_5678);
    xlate("R1", 1, 0, 32'h1234_5678, 1, 0, 1, 32'h5234_5678);
    xlate("R1", 1, 1, 32'h7FFF_FFFF, 1, 0, 1, 32'hBFFF_FFFF);
  endtask

  task automatic test_kernel_cached();
    xlate("R2", 1, 0, 32'h8000_0000, 1, 0, 1, 32'h0000_0000);
    xlate("R2", 1, 0, 32'h9FFF_FFFF, 1, 0, 1, 32'h1FFF_FFFF);
    xlate("R2", 1, 0, 32'h8ABC_DEF0, 1, 0, 1, 32'h0ABC_DEF0);
  endtask

  task automatic test_uncached();
    xlate("R3", 1, 0, 32'hA000_0000, 1, 0, 0, 32'h0000_0000);
    xlate("R3", 1, 0, 32'hBFC0_0000, 1, 0, 0, 32'h1FC0_0000);
    xlate("R3", 1, 0, 32'hBFFF_FFFF, 1, 0, 0, 32'h1FFF_FFFF);
  endtask

  task automatic test_top();
    xlate("R4", 1, 0, 32'hC000_0000, 1, 0, 1, 32'hC000_0000);
    xlate("R4", 1, 0, 32'hDEAD_BEEC, 1, 0, 1, 32'hDEAD_BEEC);
  endtask

  task automatic test_user_fault();
    xlate("R5", 1, 1, 32'h8000_0000, 0, 1, 0, 32'h0);
    xlate("R5", 1, 1, 32'hA000_1000, 0, 1, 0, 32'h0);
    xlate("R5", 1, 1, 32'hFFFF_FFFF, 0, 1, 0, 32'h0);
  endtask

  task automatic test_reserved();
    xlate("R6", 1, 1, 32'h7FF0_0000, 1, 0, 1, 32'hBFF0_0000);
    xlate("R6", 1, 0, 32'hFFF0_0000, 1, 0, 1, 32'hFFF0_0000);
    xlate("R6", 1, 0, 32'hFFFF_FFFF, 1, 0, 1, 32'hFFFF_FFFF);
  endtask

  task automatic test_idle();
    xlate("R7", 1, 0, 32'hA000_0040, 1, 0, 0, 32'h0000_0040);
    xlate("R7", 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 32'h0);
    xlate("R7", 1, 1, 32'h9000_0000, 0, 1, 0, 32'h0);
    xlate("R7", 0, 0, 32'h1000_0000, 0, 0, 0, 32'h0);
  endtask

  initial begin
    test_reset();
    test_user_segment();
    test_kernel_cached();
    test_uncached();
    test_top();
    test_user_fault();
    test_reserved();
    test_idle();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule